// File: doc/BRIEF.md
# Per-CPU Interrupt Level Combiner

This block serves one processor in a multi-processor interrupt system. It keeps a 32-bit pending word for that processor and drives fifteen interrupt-level lines, levels 1 to 15, toward the processor core. Its inputs are:

- hard levels already routed from the system-wide controller;
- a display vector of system sources mapped to level positions;
- a local timer line;
- a level-15 broadcast line;
- a global disable bit.

Software sees a small word-addressed register port. It can read the pending word, clear selected bits, and raise software interrupts in the upper fifteen bits of the word. Soft bits map onto levels by a fixed shift of sixteen places. The level-15 and timer bits bypass source masking. They are gated only by the global disable bit. Each level line is a registered, held level signal. A line moves only when its own bit of the combined vector changes.

Top module: `cpu_level_merge`

## Requirements
- R1: A read at word offset 0 returns the pending word. Reads at offsets 1, 2 and 3 return zero. The read data is combinational from the current offset.
- R2: A write at offset 1 clears the pending bits selected by the write data ANDed with 0xFFFE8000 (soft bits 31:17 and bit 15). The change is visible on the next cycle.
- R3: A write at offset 2 sets the pending bits selected by the write data ANDed with 0xFFFE0000, and no others. Writes at offsets 0 and 3 leave the pending word unchanged.
- R4: Pending bit 14 equals the timer input as sampled one clock earlier.
- R5: A rising broadcast input sets pending bit 15, and a falling one clears it. A clear write can drop the bit while the input stays high. When a broadcast edge and a clear write reach bit 15 in the same cycle, the edge wins.
- R6: Pending bits 13:1 equal display-input bits 13:1 as sampled one clock earlier. Display bits 0, 14 and 15 never reach the pending word. Pending bits 0 and 16 stay zero.
- R7: The combined level vector is formed from three terms: the hard levels, plus pending bits 15:14 when global disable is low, plus the pending word shifted right by 16. The level outputs equal that vector one clock later.
- R8: While global disable is high, pending bits 15 and 14 do not reach the outputs. Hard levels and soft levels still do.
- R9: Output bit 0 is always zero. Hard-input bit 0 is ignored.
- R10: During and right after reset, the pending word and all level outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_off | input | 2 | Word offset for both read and write |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current offset |
| hard_lvl | input | 16 | Hard levels from the system-wide controller, one bit per level |
| disp_lvl | input | 16 | Display vector of system sources at level positions |
| tmr_in | input | 1 | Local timer interrupt level |
| bcast15 | input | 1 | Level-15 broadcast line |
| glob_dis | input | 1 | Global disable |
| lvl_out | output | 16 | Interrupt-level lines; bit n is level n, bit 0 is zero |

## Verification
The bench builds the block with its default level count of sixteen. That gives a 32-bit pending word whose soft field is bits 31:17, with the broadcast bit at 15 and the timer bit at 14. With these values the exact masks 0xFFFE8000 and 0xFFFE0000 are in reach, as is the shift of soft bits onto levels 15 to 1. The tests cover these cases:

- the same-cycle race between a broadcast edge and a clear write on bit 15;
- the global-disable gate, exercised with the timer and broadcast bits while hard and soft levels are also active.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    OFF_PEND = 2'd0,
    OFF_CLR  = 2'd1,
    OFF_SET  = 2'd2,
    OFF_RSVD = 2'd3
  } reg_off_e;
endpackage

// File: rtl/irqc_pend_reg.sv
module irqc_pend_reg #(
  parameter int LVL_N = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  irqc_pkg::reg_off_e     wr_off,
  input  logic [2*LVL_N-1:0]     wr_data,
  input  logic                   tmr_i,
  input  logic                   bcast_i,
  input  logic [LVL_N-1:0]       disp_i,
  output logic [2*LVL_N-1:0]     pend_q
);
  import irqc_pkg::*;
  localparam int DW      = 2 * LVL_N;
  localparam int SOFT_LO = LVL_N + 1;
  localparam int L15_B   = LVL_N - 1;
  localparam int TMR_B   = LVL_N - 2;
  localparam logic [DW-1:0] ONE       = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] SOFT_MASK = {{(DW-SOFT_LO){1'b1}}, {SOFT_LO{1'b0}}};
  localparam logic [DW-1:0] L15_MASK  = ONE << L15_B;
  localparam logic [DW-1:0] TMR_MASK  = ONE << TMR_B;
  localparam logic [DW-1:0] DISP_MASK = (ONE << TMR_B) - (ONE << 1);

  logic [DW-1:0] clr_sel, set_sel, pend_d;
  logic          l15_n, bcast_prev_q, pend_en;

  always_comb begin
    clr_sel = (wr_en && wr_off == OFF_CLR) ? (wr_data & (SOFT_MASK | L15_MASK)) : '0;
    set_sel = (wr_en && wr_off == OFF_SET) ? (wr_data & SOFT_MASK) : '0;
    l15_n   = pend_q[L15_B] & ~clr_sel[L15_B];
    if (bcast_i != bcast_prev_q) l15_n = bcast_i;
    pend_d  = ((pend_q & SOFT_MASK & ~clr_sel) | set_sel)
            | ({{(DW-LVL_N){1'b0}}, disp_i} & DISP_MASK)
            | ({DW{l15_n}} & L15_MASK)
            | ({DW{tmr_i}} & TMR_MASK);
    pend_en = (pend_d != pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q       <= '0;
      bcast_prev_q <= 1'b0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      bcast_prev_q <= bcast_i;
    end
  end

  assert_clear_soft_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_CLR) |=> ((pend_q & SOFT_MASK & $past(wr_data)) == '0));
  assert_set_soft_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_off == OFF_SET) |=>
      ((pend_q & $past(wr_data) & SOFT_MASK) == ($past(wr_data) & SOFT_MASK)));
  assert_timer_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pend_q[TMR_B] == $past(tmr_i)));
  assert_bcast_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_i && !bcast_prev_q) |=> pend_q[L15_B]);
  assert_disp_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend_q & DISP_MASK) ==
                      ({{(DW-LVL_N){1'b0}}, $past(disp_i)} & DISP_MASK)));
endmodule

// File: rtl/irqc_level_form.sv
module irqc_level_form #(
  parameter int LVL_N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*LVL_N-1:0]   pend_i,
  input  logic [LVL_N-1:0]     hard_i,
  input  logic                 gdis_i,
  output logic [LVL_N-1:0]     lvl_d
);
  localparam int L15_B = LVL_N - 1;
  localparam int TMR_B = LVL_N - 2;

  always_comb begin
    lvl_d = hard_i | pend_i[2*LVL_N-1:LVL_N];
    if (!gdis_i) begin
      lvl_d[L15_B] = lvl_d[L15_B] | pend_i[L15_B];
      lvl_d[TMR_B] = lvl_d[TMR_B] | pend_i[TMR_B];
    end
    lvl_d[0] = 1'b0;
  end

  assert_gdis_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gdis_i && hard_i[L15_B:TMR_B] == 2'b00 && pend_i[2*LVL_N-1:2*LVL_N-2] == 2'b00)
      |-> (lvl_d[L15_B:TMR_B] == 2'b00));
endmodule

// File: rtl/irqc_out_reg.sv
module irqc_out_reg #(
  parameter int LVL_N = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_N-1:0]   lvl_d,
  output logic [LVL_N-1:0]   lvl_q
);
  assign lvl_q[0] = 1'b0;

  for (genvar g = 1; g < LVL_N; g++) begin : g_lvl
    logic q_r, q_en;
    assign q_en = (lvl_d[g] != q_r);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_r <= 1'b0;
      else if (q_en) q_r <= lvl_d[g];
    end
    assign lvl_q[g] = q_r;
  end

  assert_out_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (lvl_q[LVL_N-1:1] == $past(lvl_d[LVL_N-1:1])));
  assert_no_level0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_d[0] == 1'b0) && (lvl_q[0] == 1'b0));
endmodule

// File: rtl/cpu_level_merge.sv
module cpu_level_merge #(
  parameter int LVL_N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           reg_off,
  input  logic                 reg_wr,
  input  logic [2*LVL_N-1:0]   reg_wdata,
  output logic [2*LVL_N-1:0]   reg_rdata,
  input  logic [LVL_N-1:0]     hard_lvl,
  input  logic [LVL_N-1:0]     disp_lvl,
  input  logic                 tmr_in,
  input  logic                 bcast15,
  input  logic                 glob_dis,
  output logic [LVL_N-1:0]     lvl_out
);
  import irqc_pkg::*;
  localparam int DW = 2 * LVL_N;

  reg_off_e      off_e;
  logic [DW-1:0] pend_w;
  logic [LVL_N-1:0] lvl_next;

  assign off_e     = reg_off_e'(reg_off);
  assign reg_rdata = (off_e == OFF_PEND) ? pend_w : '0;

  irqc_pend_reg #(.LVL_N(LVL_N)) u_pend (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_off(off_e),
    .wr_data(reg_wdata), .tmr_i(tmr_in), .bcast_i(bcast15),
    .disp_i(disp_lvl), .pend_q(pend_w)
  );

  irqc_level_form #(.LVL_N(LVL_N)) u_form (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_w), .hard_i(hard_lvl),
    .gdis_i(glob_dis), .lvl_d(lvl_next)
  );

  irqc_out_reg #(.LVL_N(LVL_N)) u_out (
    .clk(clk), .rst_n(rst_n), .lvl_d(lvl_next), .lvl_q(lvl_out)
  );

  assert_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (off_e != OFF_PEND) |-> (reg_rdata == '0));
endmodule

// File: tb/cpu_level_merge_bench.sv
module cpu_level_merge_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_off = 2'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] hard_lvl = '0;
  logic [15:0] disp_lvl = '0;
  logic        tmr_in = 1'b0;
  logic        bcast15 = 1'b0;
  logic        glob_dis = 1'b0;
  logic [15:0] lvl_out;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_level_merge u_cpu_level_merge (
    .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hard_lvl(hard_lvl),
    .disp_lvl(disp_lvl), .tmr_in(tmr_in), .bcast15(bcast15),
    .glob_dis(glob_dis), .lvl_out(lvl_out)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] off, output logic [31:0] v);
    reg_off = off; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] off, input logic [31:0] d);
    reg_off = off; reg_wr = 1'b1; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0; reg_off = 2'd0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk("R10 pend", v, 32'h0);
    chk("R10 out", {16'h0, lvl_out}, 32'h0);
  endtask

  task automatic t_soft();
    logic [31:0] v;
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R3 set", v, 32'hFFFE_0000);
    tick(); chk("R7 soft levels", {16'h0, lvl_out}, 32'h0000_FFFE);
    rd(2'd1, v); chk("R1 off1", v, 32'h0);
    rd(2'd3, v); chk("R1 off3", v, 32'h0);
    wr(2'd1, 32'hAAAA_FFFF);
    rd(2'd0, v); chk("R2 clear", v, 32'h5554_0000);
    tick(); chk("R7 after clear", {16'h0, lvl_out}, 32'h0000_5554);
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R3 ignored offsets", v, 32'h5554_0000);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R2 clear all", v, 32'h0);
  endtask

  task automatic t_timer();
    logic [31:0] v;
    glob_dis = 1'b1; tmr_in = 1'b1;
    tick(); rd(2'd0, v); chk("R4 timer bit", v, 32'h0000_4000);
    tick(); chk("R8 timer gated", {16'h0, lvl_out}, 32'h0);
    glob_dis = 1'b0;
    tick(); chk("R7 timer level", {16'h0, lvl_out}, 32'h0000_4000);
    wr(2'd1, 32'h0000_4000);
    rd(2'd0, v); chk("R4 timer not clearable", v, 32'h0000_4000);
    tmr_in = 1'b0;
    tick(); rd(2'd0, v); chk("R4 timer low", v, 32'h0);
    tick(); chk("R7 timer drop", {16'h0, lvl_out}, 32'h0);
  endtask

  task automatic t_bcast();
    logic [31:0] v;
    bcast15 = 1'b1;
    wr(2'd1, 32'h0000_8000);
    rd(2'd0, v); chk("R5 edge beats clear", v, 32'h0000_8000);
    tick(); chk("R7 level15", {16'h0, lvl_out}, 32'h0000_8000);
    wr(2'd1, 32'h0000_8000);
    rd(2'd0, v); chk("R5 clear while high", v, 32'h0);
    bcast15 = 1'b0;
    tick(); rd(2'd0, v); chk("R5 fall stays clear", v, 32'h0);
    bcast15 = 1'b1;
    tick(); rd(2'd0, v); chk("R5 rise", v, 32'h0000_8000);
    glob_dis = 1'b1;
    tick(); chk("R8 level15 gated", {16'h0, lvl_out}, 32'h0);
    glob_dis = 1'b0;
    bcast15 = 1'b0;
    tick(); rd(2'd0, v); chk("R5 fall clears", v, 32'h0);
  endtask

  task automatic t_hard();
    logic [31:0] v;
    hard_lvl = 16'h8025; glob_dis = 1'b1;
    tick(); chk("R9 R8 hard passes", {16'h0, lvl_out}, 32'h0000_8024);
    hard_lvl = 16'h0001;
    tick(); chk("R9 bit0 ignored", {16'h0, lvl_out}, 32'h0);
    hard_lvl = '0; glob_dis = 1'b0;
    disp_lvl = 16'hFFFF;
    tick(); rd(2'd0, v); chk("R6 display mirror", v, 32'h0000_3FFE);
    tick(); chk("R6 display not a level", {16'h0, lvl_out}, 32'h0);
    disp_lvl = 16'h0000;
    tick(); rd(2'd0, v); chk("R6 display cleared", v, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_soft();
    t_timer();
    t_bcast();
    t_hard();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule